// File: doc/BRIEF.md
# Receive Elastic Store with Slip

This block buffers a received E1 stream between the line side and a system backplane. It holds two frames of 256 bits each (32 time slots of eight bits). Line bits arrive serially, each qualified by a write strobe. The backplane pulls bits out serially, each qualified by a read strobe. Both strobes are sampled on one fast system clock, so the two rates can differ and the read strobe can come in bursts.

The backplane side runs in one of two formats. At the E1 rate all 256 bits of a frame are read out in order. At the T1 rate each output frame is 193 bits long. It opens with a framing bit that is always 1, followed by the 24 time slots that are kept.

The read and write positions live in opposite frames, and a decision is made each time one of them reaches the end of its frame. If the reader would enter the frame still being filled, it replays its current frame. If the writer would enter the frame still being read, it refills its current frame, and the incoming frame is lost. Each such slip raises sticky flags and a one-cycle pulse. The output carries a frame-start marker and a multiframe-start marker, and a shared sync pin can act as an output or as an input.

Top module: `rx_elastic_store`

## Requirements
- R1: In E1 format (`t1_mode`=0), a line bit written at frame position p = 8*slot + bit (bit 0 of a slot arrives first) is read back at the same position of the same frame. `frame_mark` is 1 only with position 0.
- R2: Reset and a `store_rst` strobe place the writer at position 0 of frame 1 and the reader at the start of frame 0. After a `store_rst` with strobes applied together on every cycle, the read side outputs the frame written one frame earlier.
- R3: If the reader ends its frame on a cycle in which the writer does not end its frame, the reader reads the same frame again. `flag_repeat` and `flag_slip` are set.
- R4: If the writer ends its frame on a cycle in which the reader does not end its frame, the writer fills the same frame again and the frame just written is discarded. `flag_delete` and `flag_slip` are set.
- R5: When the reader and the writer end their frames on the same cycle, no slip occurs and no flag changes.
- R6: Every slip drives `slip_pulse` high for exactly one cycle. The flags stay set until they are cleared.
- R7: `flag_clr` bit 0 clears `flag_slip`, bit 1 clears `flag_repeat` and bit 2 clears `flag_delete`. A slip on the same cycle as a clear leaves its flags set.
- R8: In T1 format (`t1_mode`=1), each output frame is 193 bits. The first bit is 1. It is followed, in ascending order, by the slots whose number is not a multiple of four (slots 0, 4, 8, 12, 16, 20, 24 and 28 are left out).
- R9: In T1 format, `frame_mark` is 1 only with the framing bit.
- R10: `line_cas_mf` and `line_crc_mf` are sampled with the write of position 0 and stored with that frame. `mf_mark` is 1 with the frame's start bit when the flag selected by `mf_crc_sel` (0: CAS, 1: CRC4) was set.
- R11: With `sync_is_input`=0, `sync_out` follows `frame_mark` (`sync_mf_sel`=0) or `mf_mark` (`sync_mf_sel`=1). With `sync_is_input`=1, `sync_out` is 0. A read strobe together with `sync_in` reads the start bit of the current read frame, and the following read continues from the position after it.
- R12: After reset, every output is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock shared by both sides |
| rst_n | input | 1 | Asynchronous active-low reset |
| line_wr_en | input | 1 | Line-side write strobe |
| line_bit | input | 1 | Line data bit |
| line_cas_mf | input | 1 | CAS multiframe start, sampled at write position 0 |
| line_crc_mf | input | 1 | CRC4 multiframe start, sampled at write position 0 |
| bp_rd_en | input | 1 | Backplane read strobe |
| store_rst | input | 1 | Force the pointers into opposite frames |
| t1_mode | input | 1 | 1: 193-bit T1 readout, 0: 256-bit E1 readout |
| mf_crc_sel | input | 1 | Multiframe marker source: 0 CAS, 1 CRC4 |
| sync_is_input | input | 1 | 1: sync pin acts as an input |
| sync_mf_sel | input | 1 | Sync output marks multiframes instead of frames |
| sync_in | input | 1 | Sync input: restart at the frame start |
| flag_clr | input | 3 | Write-one-to-clear for the sticky flags |
| bp_bit | output | 1 | Backplane data bit |
| frame_mark | output | 1 | Current output bit starts a frame |
| mf_mark | output | 1 | Current output bit starts a multiframe |
| sync_out | output | 1 | Sync pin output value |
| slip_pulse | output | 1 | One-cycle pulse on a slip |
| flag_slip | output | 1 | Sticky: any slip |
| flag_repeat | output | 1 | Sticky: slip by repeating a frame |
| flag_delete | output | 1 | Sticky: slip by discarding a frame |

## Verification
Each read strobe updates `bp_bit`, `frame_mark`, `mf_mark` and `sync_out` at the clock edge that samples it. A slip shows up on `slip_pulse` and on the flags at the edge where the frame end is strobed, and a flag clear shows up at the edge that samples `flag_clr`. The bench drives one strobe per cycle and compares these outputs 1 ns after that same edge, so every result is read exactly one register stage after its cause. Frame contents follow a seeded function of frame number and position. The expected bit for any read position, including the T1 slot map, is derived from that function and the slip rules.

// File: rtl/rxes_pkg.sv
package rxes_pkg;
  localparam int NUM_SLOTS  = 32;
  localparam int SLOT_BITS  = 8;
  localparam int NUM_FRAMES = 2;
  localparam int DROP_EVERY = 4;
  localparam int FRAME_BITS = NUM_SLOTS * SLOT_BITS;
  localparam int SLOT_W     = $clog2(NUM_SLOTS);
  localparam int BIT_W      = $clog2(SLOT_BITS);
  localparam int POS_W      = SLOT_W + BIT_W;
  localparam int STORE_BITS = NUM_FRAMES * FRAME_BITS;

  typedef struct packed {
    logic crc;
    logic cas;
  } mf_tag_t;
endpackage

// File: rtl/rxes_wr_ctl.sv
module rxes_wr_ctl
  import rxes_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic             store_rst,
  input  logic             wr_hold,
  output logic             wr_frame,
  output logic [POS_W-1:0] wr_pos,
  output logic             wr_wrap
);
  logic             frame_n;
  logic [POS_W-1:0] pos_n;

  assign wr_wrap = wr_en && (wr_pos == '1);

  always_comb begin
    frame_n = wr_frame;
    pos_n   = wr_pos;
    if (store_rst) begin
      frame_n = 1'b1;
      pos_n   = '0;
    end else if (wr_en) begin
      pos_n = wr_pos + 1'b1;
      if (wr_wrap && !wr_hold) frame_n = ~wr_frame;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_frame <= 1'b1;
      wr_pos   <= '0;
    end else begin
      wr_frame <= frame_n;
      wr_pos   <= pos_n;
    end
  end

  AST_WR_HOLD_STAYS: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_hold && !store_rst) |=> (wr_frame == $past(wr_frame))); // R4
endmodule

// File: rtl/rxes_rd_ctl.sv
module rxes_rd_ctl
  import rxes_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             rd_en,
  input  logic             store_rst,
  input  logic             t1_mode,
  input  logic             sync_force,
  input  logic             rd_hold,
  output logic             rd_frame,
  output logic [POS_W-1:0] rd_addr,
  output logic             rd_is_fbit,
  output logic             rd_is_start,
  output logic             rd_wrap
);
  localparam logic [SLOT_W-1:0] DROP_MASK = SLOT_W'(DROP_EVERY - 1);
  localparam logic [SLOT_W-1:0] FIRST_KEPT = SLOT_W'(1);

  logic              fph_q, fph_e, fph_n;
  logic [SLOT_W-1:0] slot_q, slot_e, slot_n, slot_inc;
  logic [BIT_W-1:0]  bit_q, bit_e, bit_n;
  logic              frame_n;

  always_comb begin
    if (sync_force) begin
      fph_e  = t1_mode;
      slot_e = '0;
      bit_e  = '0;
    end else begin
      fph_e  = fph_q;
      slot_e = slot_q;
      bit_e  = bit_q;
    end
  end

  assign slot_inc    = slot_e + 1'b1;
  assign rd_addr     = {slot_e, bit_e};
  assign rd_is_fbit  = fph_e;
  assign rd_is_start = fph_e || (!t1_mode && slot_e == '0 && bit_e == '0);
  assign rd_wrap     = rd_en && !fph_e && (slot_e == '1) && (bit_e == '1);

  always_comb begin
    fph_n   = fph_q;
    slot_n  = slot_q;
    bit_n   = bit_q;
    frame_n = rd_frame;
    if (store_rst) begin
      fph_n   = t1_mode;
      slot_n  = '0;
      bit_n   = '0;
      frame_n = 1'b0;
    end else if (rd_en) begin
      fph_n  = 1'b0;
      slot_n = slot_e;
      bit_n  = bit_e + 1'b1;
      if (fph_e) begin
        slot_n = FIRST_KEPT;
        bit_n  = '0;
      end else if (bit_e == '1) begin
        if (slot_e == '1) begin
          slot_n = '0;
          fph_n  = t1_mode;
          if (!rd_hold) frame_n = ~rd_frame;
        end else if (t1_mode && ((slot_inc & DROP_MASK) == '0)) begin
          slot_n = slot_inc + 1'b1;
        end else begin
          slot_n = slot_inc;
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fph_q    <= 1'b0;
      slot_q   <= '0;
      bit_q    <= '0;
      rd_frame <= 1'b0;
    end else begin
      fph_q    <= fph_n;
      slot_q   <= slot_n;
      bit_q    <= bit_n;
      rd_frame <= frame_n;
    end
  end

  AST_T1_SLOT_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && t1_mode && !fph_e) |-> ((slot_e & DROP_MASK) != '0)); // R8
  AST_RD_HOLD_STAYS: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_hold && !store_rst) |=> (rd_frame == $past(rd_frame))); // R3
endmodule

// File: rtl/rxes_store.sv
module rxes_store
  import rxes_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic             wr_frame,
  input  logic [POS_W-1:0] wr_pos,
  input  logic             wr_data,
  input  logic             cas_in,
  input  logic             crc_in,
  input  logic             rd_frame,
  input  logic [POS_W-1:0] rd_addr,
  output logic             rd_raw,
  output mf_tag_t          rd_tag
);
  logic [STORE_BITS-1:0] mem;
  mf_tag_t               tag_q [NUM_FRAMES];

  always_ff @(posedge clk) begin
    if (wr_en) mem[{wr_frame, wr_pos}] <= wr_data;
  end

  for (genvar g = 0; g < NUM_FRAMES; g++) begin : g_tag
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) tag_q[g] <= '0;
      else if (wr_en && wr_pos == '0 && wr_frame == 1'(g))
        tag_q[g] <= '{crc: crc_in, cas: cas_in};
    end
  end

  assign rd_raw = mem[{rd_frame, rd_addr}];
  assign rd_tag = tag_q[rd_frame];
endmodule

// File: rtl/rx_elastic_store.sv
module rx_elastic_store
  import rxes_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       line_wr_en,
  input  logic       line_bit,
  input  logic       line_cas_mf,
  input  logic       line_crc_mf,
  input  logic       bp_rd_en,
  input  logic       store_rst,
  input  logic       t1_mode,
  input  logic       mf_crc_sel,
  input  logic       sync_is_input,
  input  logic       sync_mf_sel,
  input  logic       sync_in,
  input  logic [2:0] flag_clr,
  output logic       bp_bit,
  output logic       frame_mark,
  output logic       mf_mark,
  output logic       sync_out,
  output logic       slip_pulse,
  output logic       flag_slip,
  output logic       flag_repeat,
  output logic       flag_delete
);
  logic             wr_frame, wr_wrap, wr_hold;
  logic [POS_W-1:0] wr_pos;
  logic             rd_frame, rd_wrap, rd_hold, rd_is_fbit, rd_is_start;
  logic [POS_W-1:0] rd_addr;
  logic             rd_raw, sync_force;
  mf_tag_t          rd_tag;

  logic bit_n, fmark_n, mmark_n, slip_ev;
  logic fslip_n, frep_n, fdel_n;

  assign sync_force = sync_is_input && sync_in;

  // Reader blocked if the writer will still sit in the frame it wants next;
  // writer blocked if the reader will still sit in the frame it wants next.
  assign rd_hold = !store_rst && rd_wrap && (~rd_frame == (wr_frame ^ wr_wrap));
  assign wr_hold = !store_rst && wr_wrap && (~wr_frame == (rd_frame ^ rd_wrap));

  rxes_wr_ctl u_wr (
    .clk(clk), .rst_n(rst_n), .wr_en(line_wr_en), .store_rst(store_rst),
    .wr_hold(wr_hold), .wr_frame(wr_frame), .wr_pos(wr_pos), .wr_wrap(wr_wrap)
  );

  rxes_rd_ctl u_rd (
    .clk(clk), .rst_n(rst_n), .rd_en(bp_rd_en), .store_rst(store_rst),
    .t1_mode(t1_mode), .sync_force(sync_force), .rd_hold(rd_hold),
    .rd_frame(rd_frame), .rd_addr(rd_addr), .rd_is_fbit(rd_is_fbit),
    .rd_is_start(rd_is_start), .rd_wrap(rd_wrap)
  );

  rxes_store u_store (
    .clk(clk), .rst_n(rst_n), .wr_en(line_wr_en), .wr_frame(wr_frame),
    .wr_pos(wr_pos), .wr_data(line_bit), .cas_in(line_cas_mf),
    .crc_in(line_crc_mf), .rd_frame(rd_frame), .rd_addr(rd_addr),
    .rd_raw(rd_raw), .rd_tag(rd_tag)
  );

  always_comb begin
    slip_ev = rd_hold || wr_hold;
    fslip_n = (flag_slip   && !flag_clr[0]) || slip_ev;
    frep_n  = (flag_repeat && !flag_clr[1]) || rd_hold;
    fdel_n  = (flag_delete && !flag_clr[2]) || wr_hold;
    bit_n   = bp_bit;
    fmark_n = frame_mark;
    mmark_n = mf_mark;
    if (bp_rd_en) begin
      bit_n   = rd_is_fbit ? 1'b1 : rd_raw;
      fmark_n = rd_is_start;
      mmark_n = rd_is_start && (mf_crc_sel ? rd_tag.crc : rd_tag.cas);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bp_bit      <= 1'b0;
      frame_mark  <= 1'b0;
      mf_mark     <= 1'b0;
      slip_pulse  <= 1'b0;
      flag_slip   <= 1'b0;
      flag_repeat <= 1'b0;
      flag_delete <= 1'b0;
    end else begin
      bp_bit      <= bit_n;
      frame_mark  <= fmark_n;
      mf_mark     <= mmark_n;
      slip_pulse  <= slip_ev;
      flag_slip   <= fslip_n;
      flag_repeat <= frep_n;
      flag_delete <= fdel_n;
    end
  end

  assign sync_out = !sync_is_input && (sync_mf_sel ? mf_mark : frame_mark);

  AST_FRAMES_APART: assert property (@(posedge clk) disable iff (!rst_n)
    rd_frame != wr_frame); // R2
  AST_SLIP_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    slip_pulse |=> !slip_pulse); // R6
  AST_STICKY_SLIP: assert property (@(posedge clk) disable iff (!rst_n)
    (flag_slip && !flag_clr[0]) |=> flag_slip); // R6
  AST_REPEAT_SETS_SLIP: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(flag_repeat) |-> flag_slip); // R3
  AST_DELETE_SETS_SLIP: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(flag_delete) |-> flag_slip); // R4
  AST_FBIT_ONE: assert property (@(posedge clk) disable iff (!rst_n)
    (bp_rd_en && t1_mode && rd_is_fbit) |=> bp_bit); // R8
endmodule

// File: tb/rx_elastic_store_bench.sv
module rx_elastic_store_bench;
  logic       clk, rst_n;
  logic       line_wr_en, line_bit, line_cas_mf, line_crc_mf, bp_rd_en, store_rst;
  logic       t1_mode, mf_crc_sel, sync_is_input, sync_mf_sel, sync_in;
  logic [2:0] flag_clr;
  logic       bp_bit, frame_mark, mf_mark, sync_out, slip_pulse;
  logic       flag_slip, flag_repeat, flag_delete;
  int         n_chk, n_fail;
  logic       done;

  // [11] T1 format, [10] CRC4 marker source, [9] sync marks multiframes, [7:0] seed
  localparam logic [11:0] VEC [4] = '{12'h03C, 12'h6A5, 12'hA5E, 12'hC17};

  rx_elastic_store u_rx_elastic_store (
    .clk(clk), .rst_n(rst_n), .line_wr_en(line_wr_en), .line_bit(line_bit),
    .line_cas_mf(line_cas_mf), .line_crc_mf(line_crc_mf), .bp_rd_en(bp_rd_en),
    .store_rst(store_rst), .t1_mode(t1_mode), .mf_crc_sel(mf_crc_sel),
    .sync_is_input(sync_is_input), .sync_mf_sel(sync_mf_sel), .sync_in(sync_in),
    .flag_clr(flag_clr), .bp_bit(bp_bit), .frame_mark(frame_mark),
    .mf_mark(mf_mark), .sync_out(sync_out), .slip_pulse(slip_pulse),
    .flag_slip(flag_slip), .flag_repeat(flag_repeat), .flag_delete(flag_delete)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  function automatic logic dbit(input int seed, input int f, input int p);
    logic [7:0] v;
    v = 8'(p * 3 + f * 37 + seed * 11);
    return ^(v & 8'hB5);
  endfunction

  task automatic chk(input string req, input logic act, input logic exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0b expected %0b", req, act, exp);
    end
  endtask

  task automatic step(input logic w, input logic wb, input logic r,
                      input logic cas, input logic crc);
    line_wr_en = w; line_bit = wb; bp_rd_en = r;
    line_cas_mf = cas; line_crc_mf = crc;
    @(posedge clk); #1;
    line_wr_en = 1'b0; bp_rd_en = 1'b0; line_cas_mf = 1'b0; line_crc_mf = 1'b0;
  endtask

  task automatic clear_and_realign();
    flag_clr = 3'b111; step(0, 0, 0, 0, 0); flag_clr = 3'b000;
    store_rst = 1'b1;  step(0, 0, 0, 0, 0); store_rst = 1'b0;
  endtask

  initial begin
    done = 1'b0;
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL R12: watchdog expired, actual hung expected finished");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    n_chk = 0; n_fail = 0;
    rst_n = 1'b0; line_wr_en = 0; line_bit = 0; line_cas_mf = 0; line_crc_mf = 0;
    bp_rd_en = 0; store_rst = 0; t1_mode = 0; mf_crc_sel = 0; sync_is_input = 0;
    sync_mf_sel = 0; sync_in = 0; flag_clr = 3'b000;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    @(negedge clk);
    chk("R12", bp_bit, 0);      chk("R12", frame_mark, 0); chk("R12", mf_mark, 0);
    chk("R12", sync_out, 0);    chk("R12", slip_pulse, 0); chk("R12", flag_slip, 0);
    chk("R12", flag_repeat, 0); chk("R12", flag_delete, 0);

    // Vector table: aligned streams in each format and marker selection (R1, R2, R5, R8-R11)
    for (int v = 0; v < 4; v++) begin
      int seed;
      t1_mode = VEC[v][11]; mf_crc_sel = VEC[v][10]; sync_mf_sel = VEC[v][9];
      seed = int'(VEC[v][7:0]);
      clear_and_realign();
      for (int f = 0; f < 4; f++) begin
        for (int j = 0; j < 256; j++) begin
          logic rd, ef, em;
          int i, p, n;
          rd = !t1_mode || (j >= 63);
          step(1, dbit(seed, f, j), rd, (j == 0) && (f % 2 == 0), (j == 0) && (f % 3 == 0));
          if (rd && f >= 1) begin
            i = t1_mode ? j - 63 : j;
            ef = (i == 0);
            em = ef && (mf_crc_sel ? ((f - 1) % 3 == 0) : ((f - 1) % 2 == 0));
            if (t1_mode) begin
              if (i == 0) chk("R8", bp_bit, 1'b1);
              else begin
                n = (i - 1) / 8;
                p = (4 * (n / 3) + (n % 3) + 1) * 8 + (i - 1) % 8;
                chk("R8", bp_bit, dbit(seed, f - 1, p));
              end
              chk("R9", frame_mark, ef);
            end else begin
              chk("R1", bp_bit, dbit(seed, f - 1, i));
              chk("R1", frame_mark, ef);
            end
            chk("R10", mf_mark, em);
            chk("R11", sync_out, sync_mf_sel ? em : ef);
          end
          if (j == 255) chk("R5", slip_pulse, 0);
        end
      end
      chk("R5", flag_slip, 0); chk("R5", flag_repeat, 0); chk("R5", flag_delete, 0);
    end

    // Underflow: reader alone reaches its frame end (R3, R6, R7)
    t1_mode = 0; mf_crc_sel = 0; sync_mf_sel = 0;
    clear_and_realign();
    for (int j = 0; j < 256; j++) step(1, dbit(5, 0, j), 1, 0, 0);
    for (int j = 0; j < 256; j++) begin
      step(0, 0, 1, 0, 0);
      chk("R2", bp_bit, dbit(5, 0, j));
      if (j == 254) chk("R6", slip_pulse, 0);
    end
    chk("R3", slip_pulse, 1); chk("R3", flag_repeat, 1);
    chk("R3", flag_slip, 1);  chk("R3", flag_delete, 0);
    for (int j = 0; j < 255; j++) begin
      step(0, 0, 1, 0, 0);
      if (j == 0) chk("R6", slip_pulse, 0);
      chk("R3", bp_bit, dbit(5, 0, j));
    end
    chk("R6", flag_repeat, 1);
    flag_clr = 3'b010; step(0, 0, 0, 0, 0); flag_clr = 3'b000;
    chk("R7", flag_repeat, 0); chk("R7", flag_slip, 1);
    flag_clr = 3'b001; step(0, 0, 0, 0, 0); flag_clr = 3'b000;
    chk("R7", flag_slip, 0);
    flag_clr = 3'b011; step(0, 0, 1, 0, 0); flag_clr = 3'b000;
    chk("R7", flag_slip, 1); chk("R7", flag_repeat, 1); chk("R6", slip_pulse, 1);

    // Overflow: writer alone reaches its frame end (R4)
    clear_and_realign();
    for (int j = 0; j < 256; j++) step(1, dbit(9, 0, j), 0, 0, 0);
    chk("R4", slip_pulse, 1); chk("R4", flag_delete, 1);
    chk("R4", flag_slip, 1);  chk("R4", flag_repeat, 0);
    for (int j = 0; j < 256; j++) step(1, dbit(9, 1, j), 1, 0, 0);
    for (int j = 0; j < 256; j++) begin
      step(1, dbit(9, 2, j), 1, 0, 0);
      chk("R4", bp_bit, dbit(9, 1, j));
    end

    // Sync pin as input (R11)
    sync_is_input = 1'b1;
    clear_and_realign();
    for (int j = 0; j < 256; j++) step(1, dbit(3, 0, j), 1, 0, 0);
    for (int j = 0; j < 102; j++) begin
      sync_in = (j == 100);
      step(1, dbit(3, 1, j), 1, 0, 0);
      sync_in = 1'b0;
      if (j == 100) begin
        chk("R11", bp_bit, dbit(3, 0, 0)); chk("R11", frame_mark, 1);
        chk("R11", sync_out, 0);
      end
      if (j == 101) begin
        chk("R11", bp_bit, dbit(3, 0, 1)); chk("R11", frame_mark, 0);
      end
    end

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end
endmodule